// File: doc/BRIEF.md
# Binary Word to Hex Text Line Streamer

This block turns one 128-bit binary result, such as the output of a block cipher, into a line of text that a serial terminal can show. When a load strobe arrives while the block is idle, it captures the word. It then emits 32 lowercase hexadecimal characters followed by a carriage return and a line feed. The characters go one byte per transfer to a UART transmitter over a valid/ready handshake.

The word is read as a run of bytes. Byte 0 sits in the most significant bits and is printed leftmost. The character for each byte's upper nibble comes before the character for its lower nibble. The downstream link is expected to run at 57600 baud with 8 data bits, 1 stop bit, no parity and no flow control. That pacing reaches this block only through `tx_ready_i`. The captured copy stays fixed for the whole line, so the source may change its output as soon as the load has been taken. A one-cycle done pulse tells the requester that the line has gone out.

Top module: `hexline_tx`

## Requirements
- R1: During and after reset (active-low `rst_n`, asynchronous), `tx_valid_o`, `busy_o` and `done_o` are 0, and no character is offered until a new load is taken.
- R2: A `load_i` pulse while `busy_o` is 0 captures `data_i`. From the next cycle, `tx_valid_o` and `busy_o` are 1.
- R3: A nibble value n from 0 to 9 is sent as the byte 0x30+n. A value from 10 to 15 is sent as 0x61+(n-10), that is, lowercase 'a' to 'f'.
- R4: Hex character k (k = 0..31) encodes bits [127-4k : 124-4k] of the captured word. So byte 0 is bits 127:120 and is sent first, and each byte sends its bits 7:4 before its bits 3:0.
- R5: After the 32nd hex character is accepted, the block offers 0x0D, and after that 0x0A.
- R6: A character advances only in a cycle where `tx_valid_o` and `tx_ready_i` are both 1. While `tx_valid_o` is 1 and `tx_ready_i` is 0, `tx_valid_o` stays 1 and `tx_data_o` stays unchanged in the next cycle.
- R7: `load_i` and any change of `data_i` while `busy_o` is 1 have no effect. The remaining characters still come from the word first captured, and no second line follows.
- R8: `done_o` is 1 for exactly one cycle, the cycle right after the line feed is accepted. In that cycle `busy_o` is 0, and a load in that cycle is taken.
- R9: Each taken load yields exactly 34 accepted characters, and `tx_valid_o` is 1 throughout that line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture strobe, honoured only while idle |
| data_i | input | 128 | Binary word to print, byte 0 in bits 127:120 |
| busy_o | output | 1 | A line is in progress |
| tx_valid_o | output | 1 | A character is offered to the transmitter |
| tx_data_o | output | 8 | ASCII character offered |
| tx_ready_i | input | 1 | Transmitter accepts the offered character |
| done_o | output | 1 | One-cycle pulse after the final character is accepted |

## Verification
The assertions check the handshake rules on every cycle. An offered character must stay still under back-pressure, every offered byte must be a legal hex digit or line terminator, a carriage return must be followed by a line feed, and the line feed must be the 34th acceptance since the load. They also check that done is a single-cycle pulse that follows the line feed. Which digit appears at each position, and whether a load during a busy line or a changed input word leaks into the output, depends on the captured value. Only the bench's scenarios can show that, by comparing whole lines against independently computed text under several back-pressure patterns, a mid-line reset and a load on the done cycle.

// File: rtl/hexline_pkg.sv
package hexline_pkg;

  localparam logic [7:0] ASCII_CR = 8'h0D;
  localparam logic [7:0] ASCII_LF = 8'h0A;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HEX  = 2'd1,
    PH_CR   = 2'd2,
    PH_LF   = 2'd3
  } phase_e;

  // Nibble to lowercase ASCII hex digit.
  function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    else           return 8'h57 + {4'h0, n};
  endfunction

  // True for any byte the streamer may legally offer.
  function automatic logic is_line_char(input logic [7:0] c);
    return ((c >= 8'h30) && (c <= 8'h39)) ||
           ((c >= 8'h61) && (c <= 8'h66)) ||
           (c == ASCII_CR) || (c == ASCII_LF);
  endfunction

endpackage

// File: rtl/hexline_capture.sv
module hexline_capture #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] word_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_o <= '0;
    else if (take_i) word_o <= data_i;
  end

endmodule

// File: rtl/hexline_seq.sv
module hexline_seq
  import hexline_pkg::*;
#(
  parameter int NIBBLES = 32,
  localparam int IDX_W  = (NIBBLES > 1) ? $clog2(NIBBLES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             accept_i,
  output phase_e           phase_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIBBLES - 1);

  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_d;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (take_i) begin
          phase_d = PH_HEX;
          idx_d   = '0;
        end
      end
      PH_HEX: begin
        if (accept_i) begin
          if (idx_q == LAST_IDX) phase_d = PH_CR;
          else                   idx_d   = idx_q + 1'b1;
        end
      end
      PH_CR: begin
        if (accept_i) phase_d = PH_LF;
      end
      PH_LF: begin
        if (accept_i) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      done_o  <= done_d;
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign busy_o  = (phase_q != PH_IDLE);

endmodule

// File: rtl/hexline_enc.sv
module hexline_enc
  import hexline_pkg::*;
#(
  parameter int DATA_W  = 128,
  localparam int NIBBLES = DATA_W / 4,
  localparam int IDX_W   = (NIBBLES > 1) ? $clog2(NIBBLES) : 1
) (
  input  logic [DATA_W-1:0] word_i,
  input  phase_e            phase_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [7:0]        char_o
);

  // Nibble g counts from the most significant end of the word.
  logic [3:0] nib [NIBBLES];

  for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
    assign nib[g] = word_i[DATA_W-1-4*g -: 4];
  end

  always_comb begin
    unique case (phase_i)
      PH_HEX:  char_o = nib_to_ascii(nib[idx_i]);
      PH_CR:   char_o = ASCII_CR;
      PH_LF:   char_o = ASCII_LF;
      default: char_o = 8'h00;
    endcase
  end

endmodule

// File: rtl/hexline_tx.sv
module hexline_tx
  import hexline_pkg::*;
#(
  parameter int DATA_W = 128,
  localparam int NIBBLES = DATA_W / 4,
  localparam int IDX_W   = (NIBBLES > 1) ? $clog2(NIBBLES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_ready_i,
  output logic              done_o
);

  // Named internal events, also observed by the bound checker.
  logic              take_w;
  logic              accept_w;
  logic              busy_w;
  phase_e            phase_w;
  logic [IDX_W-1:0]  idx_w;
  logic [DATA_W-1:0] word_w;
  logic [7:0]        char_w;

  assign take_w   = load_i & ~busy_w;
  assign accept_w = busy_w & tx_ready_i;

  hexline_capture #(.DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (take_w),
    .data_i (data_i),
    .word_o (word_w)
  );

  hexline_seq #(.NIBBLES(NIBBLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (take_w),
    .accept_i (accept_w),
    .phase_o  (phase_w),
    .idx_o    (idx_w),
    .busy_o   (busy_w),
    .done_o   (done_o)
  );

  hexline_enc #(.DATA_W(DATA_W)) u_enc (
    .word_i  (word_w),
    .phase_i (phase_w),
    .idx_i   (idx_w),
    .char_o  (char_w)
  );

  assign busy_o     = busy_w;
  assign tx_valid_o = busy_w;
  assign tx_data_o  = char_w;

endmodule

// File: rtl/hexline_chk.sv
module hexline_chk
  import hexline_pkg::*;
#(
  parameter int DATA_W = 128,
  localparam int CHARS = DATA_W / 4 + 2,
  localparam int CNT_W = $clog2(CHARS + 1)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       take_w,
  input logic       accept_w,
  input logic       busy_o,
  input logic       tx_valid_o,
  input logic [7:0] tx_data_o,
  input logic       tx_ready_i,
  input logic       done_o
);

  // Characters accepted since the last taken load.
  logic [CNT_W-1:0] acc_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_cnt <= '0;
    else if (take_w)   acc_cnt <= '0;
    else if (accept_w) acc_cnt <= acc_cnt + 1'b1;
  end

  logic lf_taken;
  assign lf_taken = accept_w && (tx_data_o == ASCII_LF);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!tx_valid_o && !busy_o && !done_o));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> (tx_valid_o && busy_o));

  p_charset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> is_line_char(tx_data_o));

  p_cr_then_lf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && (tx_data_o == ASCII_CR)) |=> (tx_valid_o && (tx_data_o == ASCII_LF)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  p_done_after_lf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lf_taken |=> (done_o && !busy_o));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_line_length_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lf_taken |-> (acc_cnt == CNT_W'(CHARS - 1)));

endmodule

bind hexline_tx hexline_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .take_w     (take_w),
  .accept_w   (accept_w),
  .busy_o     (busy_o),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .tx_ready_i (tx_ready_i),
  .done_o     (done_o)
);

// File: tb/hexline_tx_tb.sv
module hexline_tx_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_i;
  logic [127:0] data_i;
  logic         busy_o;
  logic         tx_valid_o;
  logic [7:0]   tx_data_o;
  logic         tx_ready_i;
  logic         done_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  hexline_tx u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .data_i     (data_i),
    .busy_o     (busy_o),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_ready_i (tx_ready_i),
    .done_o     (done_o)
  );

  // {ready pattern, word}
  localparam logic [135:0] VECS [4] = '{
    {8'hFF, 128'h0123456789abcdef_fedcba9876543210},
    {8'hA5, 128'h00000000000000000000000000000000},
    {8'h0F, 128'hffffffffffffffffffffffffffffffff},
    {8'h81, 128'hdeadbeef00c0ffeea5a55a5a13579bdf}
  };

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected text, by lookup table rather than arithmetic.
  function automatic logic [7:0] exp_char(input logic [127:0] v, input int k);
    string digits = "0123456789abcdef";
    logic [127:0] sh;
    if (k == 32) return 8'h0D;
    if (k == 33) return 8'h0A;
    sh = v >> (4 * (31 - k));
    return digits[int'(sh[3:0])];
  endfunction

  // Called right after a negedge: take effect at the coming posedge.
  task automatic do_load(input logic [127:0] v);
    data_i = v;
    load_i = 1'b1;
    @(posedge clk);
    #1 load_i = 1'b0;
  endtask

  // Receive one line; inj >= 0 pulses a load with other data at that cycle.
  // Returns at the negedge where done should be high.
  task automatic rx_line(input logic [127:0] v, input logic [7:0] pat, input int inj);
    int k = 0;
    int cyc = 0;
    logic [7:0] prev = 8'h00;
    bit held = 1'b0;
    while (k < 34 && cyc < 2000) begin
      @(negedge clk);
      if (cyc == 0) check(tx_valid_o && busy_o, "R2 line starts after load", {tx_valid_o, busy_o}, 2'b11);
      if (held) check(tx_valid_o && tx_data_o == prev, "R6 held under back-pressure", tx_data_o, prev);
      check(tx_valid_o, "R9 valid through line", tx_valid_o, 1);
      load_i = (cyc == inj);
      if (inj >= 0 && cyc >= inj) data_i = ~v;
      tx_ready_i = pat[cyc % 8];
      if (tx_ready_i) begin
        if (k < 32) check(tx_data_o == exp_char(v, k), "R3 R4 R7 hex digit order", tx_data_o, exp_char(v, k));
        else        check(tx_data_o == exp_char(v, k), "R5 line terminator", tx_data_o, exp_char(v, k));
        k++;
        held = 1'b0;
      end else begin
        held = 1'b1;
        prev = tx_data_o;
      end
      cyc++;
    end
    @(negedge clk);
    load_i = 1'b0;
    tx_ready_i = 1'b0;
    check(done_o && !tx_valid_o && !busy_o, "R8 R9 done after line feed",
          {done_o, tx_valid_o, busy_o}, 3'b100);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    load_i = 1'b0;
    data_i = '0;
    tx_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    check(!tx_valid_o && !busy_o && !done_o, "R1 reset idle", {tx_valid_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    tx_ready_i = 1'b1;
    repeat (2) @(negedge clk);
    check(!tx_valid_o && !busy_o && !done_o, "R1 idle without load", {tx_valid_o, busy_o, done_o}, 0);
    tx_ready_i = 1'b0;

    // Table-driven lines under several back-pressure patterns.
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      do_load(VECS[i][127:0]);
      rx_line(VECS[i][127:0], VECS[i][135:128], -1);
      @(negedge clk);
      check(!done_o, "R8 done lasts one cycle", done_o, 0);
    end

    // R7: load and data change mid-line are ignored; no second line.
    @(negedge clk);
    do_load(128'h89abcdef_01234567_76543210_fedcba98);
    rx_line(128'h89abcdef_01234567_76543210_fedcba98, 8'h6D, 5);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      check(!tx_valid_o && !busy_o, "R7 no line from ignored load", {tx_valid_o, busy_o}, 0);
    end

    // R8: load on the done cycle is taken.
    @(negedge clk);
    do_load(128'h11223344556677889900aabbccddeeff);
    rx_line(128'h11223344556677889900aabbccddeeff, 8'hFF, -1);
    do_load(128'hcafef00d_0badc0de_5a5a5a5a_00ff00ff);
    rx_line(128'hcafef00d_0badc0de_5a5a5a5a_00ff00ff, 8'h33, -1);

    // R1: reset in the middle of a line returns to idle.
    @(negedge clk);
    do_load(128'h0f0f0f0f0f0f0f0f0f0f0f0f0f0f0f0f);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1 check(!tx_valid_o && !busy_o && !done_o, "R1 mid-line reset", {tx_valid_o, busy_o, done_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tx_valid_o && !busy_o, "R1 idle after reset release", {tx_valid_o, busy_o}, 0);
    do_load(128'h3c3c3c3c3c3c3c3c3c3c3c3c3c3c3c3c);
    rx_line(128'h3c3c3c3c3c3c3c3c3c3c3c3c3c3c3c3c, 8'hFF, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule